// File: doc/BRIEF.md
# Debug Module Register Interface

This block is the register front end of a small debug unit for 32-bit RISC-V harts. A debugger reaches it over APB and finds a control register, a status register, hart information, abstract-command control and status, the command register, an auto-execution register, one data word, one program-buffer word and two halt-summary words. The block selects one hart at a time out of up to 64 harts. It drives that hart's halt and resume requests, and it runs abstract commands against the hart's debug controller.

A command is accepted only when the unit is idle and no error is pending. When a command is accepted, the block raises a one-cycle start pulse and presents the command word, the data word and the program-buffer word to the hart side. It then stays busy until the hart reports completion. Completion carries a result word and an exception flag. Any access made while a command is in flight records a sticky error code, and the debugger clears that code by writing ones to it. Either auto-execution bit makes an access to the data word or the program-buffer word run the last accepted command again.

Top module: `dm_regif`

## Requirements
- R1: After reset, abstract status (word 0x16) reads 0x01000001, which is program-buffer size 1 in bits 28:24 and data count 1 in bits 3:0, with busy (bit 12) and error (bits 10:8) clear. Data (0x04), program buffer (0x20) and command-side outputs read zero, and `cmd_start` is low.
- R2: Every access completes in its first access phase, with `pready` high and `pslverr` low. Unmapped words read zero. The window-select (0x14), window (0x15), authentication (0x30), device-tree (0x19) and next-unit (0x1a) words read zero, and writes to them change nothing. Hart info (0x12) reads the scratch count in bits 23:20.
- R3: A write to control (0x10) sets the halt request from bit 31, the resume request from bit 30, the hart index from bits 25:16, the system reset from bit 1 and the active flag from bit 0. These drive `halt_req`, `resume_req`, `hart_sel`, `ndm_reset` and `dm_active`. Reads return only bits 25:16, 1 and 0.
- R4: Status (0x11) reads version 2 in bits 3:0, authenticated (bit 7) and implicit breakpoint (bit 22), each always set. For an existing selected hart, halted sets bits 9 and 8, and running sets bits 11 and 10. Each pair always holds equal values. An index at or beyond the hart count sets bits 15 and 14 and clears bits 11:8.
- R5: A command write (0x17) while idle with no error stores the word, sets busy, and raises `cmd_start` for exactly the one cycle after the write. `cmd_word`, `cmd_arg` and `cmd_instr` present the stored command, data and program buffer.
- R6: A command write while busy sets the error to 1 when it was zero and leaves the stored command unchanged.
- R7: A command write while the error is nonzero starts nothing and leaves the error unchanged.
- R8: A read or write of data or program buffer while busy sets the error to 1 when it was zero. Such a write leaves the word unchanged.
- R9: Completion (`cmd_done`) clears busy. If `cmd_exc` is also high, the error becomes 3 when it was zero. If the command has transfer (bit 17) set and write (bit 16) clear, data takes `cmd_result`.
- R10: Writing abstract status clears each error bit written as 1.
- R11: Auto-execution (0x18) holds a data bit at bit 0 and a program-buffer bit at bit 16. When a bit is set, an access to its word while idle with no error re-runs the stored command as in R5, and a write takes effect before the start.
- R12: Halt summary 0 (0x40) reads the halted flags of harts 0 to 31. With more than 32 harts, halt summary 1 (0x13) reads, in bit 0, whether any of harts 0 to 31 are halted and, in bit 1, whether any of harts 32 to 63 are halted. Otherwise it reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable |
| pwrite | input | 1 | APB write |
| paddr | input | ADDR_W | APB word address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error, always low |
| hart_halted | input | NUM_HARTS | Halted flag per hart |
| hart_sel | output | SEL_W | Selected hart index |
| halt_req | output | 1 | Halt request to selected hart |
| resume_req | output | 1 | Resume request to selected hart |
| ndm_reset | output | 1 | System reset request |
| dm_active | output | 1 | Debug unit active flag |
| cmd_start | output | 1 | One-cycle command start pulse |
| cmd_word | output | 32 | Stored abstract command |
| cmd_arg | output | 32 | Data word for the command |
| cmd_instr | output | 32 | Program-buffer instruction |
| cmd_done | input | 1 | Command completion from hart |
| cmd_exc | input | 1 | Completion raised an exception |
| cmd_result | input | 32 | Result word at completion |

## Verification
The bench builds the block with 40 harts and one scratch register. That count makes halt summary 1 active and lets it exercise both groups, harts 0 to 31 and harts 32 to 39. Selecting hart index 45 falls outside the configured count and reaches the nonexistent-hart status path. The bench also drives every ordering of command, data and program-buffer accesses against busy and a pending error, and both auto-execution triggers.

// File: rtl/dm_pkg.sv
package dm_pkg;

    localparam int MAX_HARTS  = 64;
    localparam int HSEL_W     = 10;
    localparam int DM_VERSION = 2;

    localparam logic [7:0] A_DATA0  = 8'h04;
    localparam logic [7:0] A_CTRL   = 8'h10;
    localparam logic [7:0] A_STAT   = 8'h11;
    localparam logic [7:0] A_HINFO  = 8'h12;
    localparam logic [7:0] A_HSUM1  = 8'h13;
    localparam logic [7:0] A_WSEL   = 8'h14;
    localparam logic [7:0] A_WIN    = 8'h15;
    localparam logic [7:0] A_ACS    = 8'h16;
    localparam logic [7:0] A_CMD    = 8'h17;
    localparam logic [7:0] A_AUTO   = 8'h18;
    localparam logic [7:0] A_DTREE  = 8'h19;
    localparam logic [7:0] A_NEXT   = 8'h1a;
    localparam logic [7:0] A_PBUF0  = 8'h20;
    localparam logic [7:0] A_AUTH   = 8'h30;
    localparam logic [7:0] A_HSUM0  = 8'h40;

    localparam logic [2:0] ERR_NONE = 3'd0;
    localparam logic [2:0] ERR_BUSY = 3'd1;
    localparam logic [2:0] ERR_EXC  = 3'd3;

    typedef enum logic [2:0] {
        WR_NONE,
        WR_CTRL,
        WR_ACS,
        WR_CMD,
        WR_AUTO,
        WR_DATA0,
        WR_PBUF0
    } wr_act_e;

    typedef enum logic [3:0] {
        RD_ZERO,
        RD_CTRL,
        RD_STAT,
        RD_HINFO,
        RD_ACS,
        RD_AUTO,
        RD_DATA0,
        RD_PBUF0,
        RD_HSUM0,
        RD_HSUM1
    } rd_sel_e;

    typedef struct packed {
        logic              halt;
        logic              resume;
        logic [HSEL_W-1:0] hartsel;
        logic              sysreset;
        logic              active;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
        ctrl_t c;
        c.halt     = w[31];
        c.resume   = w[30];
        c.hartsel  = w[25:16];
        c.sysreset = w[1];
        c.active   = w[0];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
        logic [31:0] w;
        w        = '0;
        w[25:16] = c.hartsel;
        w[1]     = c.sysreset;
        w[0]     = c.active;
        return w;
    endfunction

    function automatic logic cmd_returns_data(input logic [31:0] cmd);
        return cmd[17] && !cmd[16];
    endfunction

endpackage

// File: rtl/dm_reg_decode.sv
module dm_reg_decode
    import dm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              access,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    output wr_act_e           wr_act,
    output rd_sel_e           rd_sel,
    output logic              data_touch,
    output logic              pbuf_touch
);

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] r);
        return a == ADDR_W'(r);
    endfunction

    always_comb begin
        rd_sel = RD_ZERO;
        if      (hit(addr, A_CTRL))  rd_sel = RD_CTRL;
        else if (hit(addr, A_STAT))  rd_sel = RD_STAT;
        else if (hit(addr, A_HINFO)) rd_sel = RD_HINFO;
        else if (hit(addr, A_ACS))   rd_sel = RD_ACS;
        else if (hit(addr, A_AUTO))  rd_sel = RD_AUTO;
        else if (hit(addr, A_DATA0)) rd_sel = RD_DATA0;
        else if (hit(addr, A_PBUF0)) rd_sel = RD_PBUF0;
        else if (hit(addr, A_HSUM0)) rd_sel = RD_HSUM0;
        else if (hit(addr, A_HSUM1)) rd_sel = RD_HSUM1;
    end

    always_comb begin
        wr_act = WR_NONE;
        if (access && write) begin
            if      (hit(addr, A_CTRL))  wr_act = WR_CTRL;
            else if (hit(addr, A_ACS))   wr_act = WR_ACS;
            else if (hit(addr, A_CMD))   wr_act = WR_CMD;
            else if (hit(addr, A_AUTO))  wr_act = WR_AUTO;
            else if (hit(addr, A_DATA0)) wr_act = WR_DATA0;
            else if (hit(addr, A_PBUF0)) wr_act = WR_PBUF0;
        end
    end

    assign data_touch = access && hit(addr, A_DATA0);
    assign pbuf_touch = access && hit(addr, A_PBUF0);

endmodule

// File: rtl/dm_hart_status.sv
module dm_hart_status
    import dm_pkg::*;
#(
    parameter int NUM_HARTS = 64,
    parameter int SEL_W     = 6
) (
    input  logic [NUM_HARTS-1:0] halted,
    input  logic [HSEL_W-1:0]    hartsel,
    output logic [SEL_W-1:0]     sel_idx,
    output logic [31:0]          status_word,
    output logic [31:0]          hsum0,
    output logic [31:0]          hsum1
);

    logic [MAX_HARTS-1:0] pad;
    logic                 exists;
    logic                 cur_halted;

    always_comb begin
        pad = '0;
        for (int i = 0; i < NUM_HARTS; i++) pad[i] = halted[i];
    end

    assign exists  = 32'(hartsel) < NUM_HARTS;
    assign sel_idx = hartsel[SEL_W-1:0];

    always_comb begin
        cur_halted = 1'b0;
        for (int i = 0; i < NUM_HARTS; i++)
            if (32'(hartsel) == i) cur_halted = halted[i];
    end

    always_comb begin
        status_word        = '0;
        status_word[3:0]   = 4'(DM_VERSION);
        status_word[7]     = 1'b1;
        status_word[22]    = 1'b1;
        status_word[9]     = exists && cur_halted;
        status_word[8]     = exists && cur_halted;
        status_word[11]    = exists && !cur_halted;
        status_word[10]    = exists && !cur_halted;
        status_word[15]    = !exists;
        status_word[14]    = !exists;
    end

    assign hsum0 = pad[31:0];

    generate
        if (NUM_HARTS > 32) begin : g_two_groups
            assign hsum1 = {30'b0, |pad[63:32], |pad[31:0]};
        end else begin : g_one_group
            assign hsum1 = '0;
        end
    endgenerate

endmodule

// File: rtl/dm_abs_ctrl.sv
module dm_abs_ctrl
    import dm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  wr_act_e     wr_act,
    input  logic        data_touch,
    input  logic        pbuf_touch,
    input  logic [31:0] wdata,
    input  logic        cmd_done,
    input  logic        cmd_exc,
    input  logic [31:0] cmd_result,
    output logic [31:0] acs_word,
    output logic [31:0] auto_word,
    output logic [31:0] data0,
    output logic [31:0] pbuf0,
    output logic [31:0] cmd_word,
    output logic        cmd_start
);

    logic        busy_q;
    logic [2:0]  err_q;
    logic [31:0] cmd_q;
    logic [31:0] data0_q;
    logic [31:0] pbuf0_q;
    logic        auto_data_q;
    logic        auto_pbuf_q;
    logic        start_q;

    logic cmd_wr;
    logic busy_hit;
    logic launch;

    assign cmd_wr   = wr_act == WR_CMD;
    assign busy_hit = busy_q && (cmd_wr || data_touch || pbuf_touch);
    assign launch   = !busy_q && (err_q == ERR_NONE) &&
                      (cmd_wr || (data_touch && auto_data_q) ||
                       (pbuf_touch && auto_pbuf_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q      <= 1'b0;
            err_q       <= ERR_NONE;
            cmd_q       <= '0;
            data0_q     <= '0;
            pbuf0_q     <= '0;
            auto_data_q <= 1'b0;
            auto_pbuf_q <= 1'b0;
            start_q     <= 1'b0;
        end else begin
            start_q <= launch;
            if (wr_act == WR_ACS)
                err_q <= err_q & ~wdata[10:8];
            if (wr_act == WR_AUTO) begin
                auto_data_q <= wdata[0];
                auto_pbuf_q <= wdata[16];
            end
            if (wr_act == WR_DATA0 && !busy_q) data0_q <= wdata;
            if (wr_act == WR_PBUF0 && !busy_q) pbuf0_q <= wdata;
            if (launch) begin
                busy_q <= 1'b1;
                if (cmd_wr) cmd_q <= wdata;
            end
            if (busy_hit && err_q == ERR_NONE)
                err_q <= ERR_BUSY;
            if (busy_q && cmd_done) begin
                busy_q <= 1'b0;
                if (cmd_exc) begin
                    if (err_q == ERR_NONE) err_q <= ERR_EXC;
                end else if (cmd_returns_data(cmd_q)) begin
                    data0_q <= cmd_result;
                end
            end
        end
    end

    always_comb begin
        acs_word        = '0;
        acs_word[28:24] = 5'd1;
        acs_word[12]    = busy_q;
        acs_word[10:8]  = err_q;
        acs_word[3:0]   = 4'd1;
    end

    assign auto_word = {15'b0, auto_pbuf_q, 15'b0, auto_data_q};
    assign data0     = data0_q;
    assign pbuf0     = pbuf0_q;
    assign cmd_word  = cmd_q;
    assign cmd_start = start_q;

    AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (rst)
        start_q |-> busy_q); // R5

    AST_BUSY_CMD_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cmd_wr && err_q == ERR_NONE && !cmd_done) |=>
        (err_q == ERR_BUSY && cmd_q == $past(cmd_q))); // R6

    AST_ERR_BLOCKS_START: assert property (@(posedge clk) disable iff (rst)
        (err_q != ERR_NONE && !busy_q) |=> !start_q); // R7

    AST_BUSY_WR_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !cmd_done && wr_act == WR_PBUF0) |=> $stable(pbuf0_q)); // R8

    AST_EXC_TO_ERR: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cmd_done && cmd_exc && err_q == ERR_NONE) |=>
        (err_q == ERR_EXC && !busy_q)); // R9

endmodule

// File: rtl/dm_regif.sv
module dm_regif
    import dm_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_HARTS = 64,
    parameter int NSCRATCH  = 1,
    localparam int SEL_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [ADDR_W-1:0]    paddr,
    input  logic [31:0]          pwdata,
    output logic [31:0]          prdata,
    output logic                 pready,
    output logic                 pslverr,
    input  logic [NUM_HARTS-1:0] hart_halted,
    output logic [SEL_W-1:0]     hart_sel,
    output logic                 halt_req,
    output logic                 resume_req,
    output logic                 ndm_reset,
    output logic                 dm_active,
    output logic                 cmd_start,
    output logic [31:0]          cmd_word,
    output logic [31:0]          cmd_arg,
    output logic [31:0]          cmd_instr,
    input  logic                 cmd_done,
    input  logic                 cmd_exc,
    input  logic [31:0]          cmd_result
);

    logic        access;
    wr_act_e     wr_act;
    rd_sel_e     rd_sel;
    logic        data_touch;
    logic        pbuf_touch;
    ctrl_t       ctrl_q;
    logic [31:0] stat_w, hsum0_w, hsum1_w, acs_w, auto_w, data0_w, pbuf0_w;
    logic [31:0] hinfo_w;

    assign access  = psel && penable;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    dm_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .access     (access),
        .write      (pwrite),
        .addr       (paddr),
        .wr_act     (wr_act),
        .rd_sel     (rd_sel),
        .data_touch (data_touch),
        .pbuf_touch (pbuf_touch)
    );

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else if (wr_act == WR_CTRL) ctrl_q <= ctrl_from_word(pwdata);
    end

    assign halt_req   = ctrl_q.halt;
    assign resume_req = ctrl_q.resume;
    assign ndm_reset  = ctrl_q.sysreset;
    assign dm_active  = ctrl_q.active;

    dm_hart_status #(.NUM_HARTS(NUM_HARTS), .SEL_W(SEL_W)) u_stat (
        .halted      (hart_halted),
        .hartsel     (ctrl_q.hartsel),
        .sel_idx     (hart_sel),
        .status_word (stat_w),
        .hsum0       (hsum0_w),
        .hsum1       (hsum1_w)
    );

    dm_abs_ctrl u_abs (
        .clk        (clk),
        .rst        (rst),
        .wr_act     (wr_act),
        .data_touch (data_touch),
        .pbuf_touch (pbuf_touch),
        .wdata      (pwdata),
        .cmd_done   (cmd_done),
        .cmd_exc    (cmd_exc),
        .cmd_result (cmd_result),
        .acs_word   (acs_w),
        .auto_word  (auto_w),
        .data0      (data0_w),
        .pbuf0      (pbuf0_w),
        .cmd_word   (cmd_word),
        .cmd_start  (cmd_start)
    );

    assign cmd_arg   = data0_w;
    assign cmd_instr = pbuf0_w;
    assign hinfo_w   = {8'b0, 4'(NSCRATCH), 20'b0};

    always_comb begin
        case (rd_sel)
            RD_CTRL:  prdata = ctrl_to_word(ctrl_q);
            RD_STAT:  prdata = stat_w;
            RD_HINFO: prdata = hinfo_w;
            RD_ACS:   prdata = acs_w;
            RD_AUTO:  prdata = auto_w;
            RD_DATA0: prdata = data0_w;
            RD_PBUF0: prdata = pbuf0_w;
            RD_HSUM0: prdata = hsum0_w;
            RD_HSUM1: prdata = hsum1_w;
            default:  prdata = '0;
        endcase
    end

    AST_SEL_FOLLOWS_CTRL: assert property (@(posedge clk) disable iff (rst)
        (wr_act == WR_CTRL) |=> (hart_sel == $past(pwdata[16 +: SEL_W]))); // R3

endmodule

// File: tb/tb_dm_regif.sv
`timescale 1ns/100ps
module tb_dm_regif;

    localparam int NH = 40;
    localparam int SW = $clog2(NH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]    paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic          pready, pslverr;
    logic [NH-1:0] hart_halted = '0;
    logic [SW-1:0] hart_sel;
    logic          halt_req, resume_req, ndm_reset, dm_active;
    logic          cmd_start;
    logic [31:0]   cmd_word, cmd_arg, cmd_instr;
    logic          cmd_done = 1'b0, cmd_exc = 1'b0;
    logic [31:0]   cmd_result = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    dm_regif #(.ADDR_W(8), .NUM_HARTS(NH), .NSCRATCH(1)) dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .hart_halted(hart_halted), .hart_sel(hart_sel),
        .halt_req(halt_req), .resume_req(resume_req), .ndm_reset(ndm_reset),
        .dm_active(dm_active), .cmd_start(cmd_start), .cmd_word(cmd_word),
        .cmd_arg(cmd_arg), .cmd_instr(cmd_instr), .cmd_done(cmd_done),
        .cmd_exc(cmd_exc), .cmd_result(cmd_result)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares each read's data in its access phase
    always @(negedge clk) begin
        #1;
        if (psel && penable && !pwrite && exp_q.size() > 0) begin
            automatic logic [31:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(t, prdata, e);
        end
    end

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        #0.5;
    endtask

    task automatic apb_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        #0.5;
    endtask

    task automatic hart_finish(input logic exc, input logic [31:0] res);
        @(negedge clk);
        cmd_done = 1'b1; cmd_exc = exc; cmd_result = res;
        @(negedge clk);
        cmd_done = 1'b0; cmd_exc = 1'b0;
        #0.5;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #0.5;

        // R1 reset state
        check("R1 cmd_start", {31'b0, cmd_start}, 32'h0);
        check("R1 cmd_word", cmd_word, 32'h0);
        apb_rd(8'h16, 32'h0100_0001, "R1 abstract status");
        apb_rd(8'h04, 32'h0, "R1 data");
        apb_rd(8'h20, 32'h0, "R1 progbuf");
        apb_rd(8'h11, 32'h0040_0C82, "R4 status running hart 0");

        // R2 unmapped and zero words
        check("R2 pready", {31'b0, pready}, 32'h1);
        check("R2 pslverr", {31'b0, pslverr}, 32'h0);
        apb_rd(8'h7F, 32'h0, "R2 unmapped");
        apb_wr(8'h14, 32'hFFFF_FFFF);
        apb_rd(8'h14, 32'h0, "R2 window select");
        apb_wr(8'h30, 32'h1234_5678);
        apb_rd(8'h30, 32'h0, "R2 auth");
        apb_rd(8'h1a, 32'h0, "R2 next unit");
        apb_rd(8'h12, 32'h0010_0000, "R2 hart info");

        // R3 control
        apb_wr(8'h10, 32'h8003_0003);
        check("R3 halt_req", {31'b0, halt_req}, 32'h1);
        check("R3 hart_sel", 32'(hart_sel), 32'd3);
        check("R3 dm_active", {31'b0, dm_active}, 32'h1);
        check("R3 ndm_reset", {31'b0, ndm_reset}, 32'h1);
        apb_rd(8'h10, 32'h0003_0003, "R3 control readback");
        apb_wr(8'h10, 32'h4003_0001);
        check("R3 resume_req", {30'b0, resume_req, halt_req}, 32'h2);

        // R4 status
        hart_halted[3] = 1'b1;
        apb_rd(8'h11, 32'h0040_0382, "R4 status halted");
        apb_wr(8'h10, 32'h002D_0001);
        apb_rd(8'h11, 32'h0040_C082, "R4 status nonexistent");
        apb_wr(8'h10, 32'h0000_0001);

        // R12 halt summaries
        hart_halted = '0; hart_halted[3] = 1'b1; hart_halted[35] = 1'b1;
        apb_rd(8'h40, 32'h0000_0008, "R12 summary0");
        apb_rd(8'h13, 32'h0000_0003, "R12 summary1 both");
        hart_halted[3] = 1'b0;
        apb_rd(8'h40, 32'h0, "R12 summary0 empty");
        apb_rd(8'h13, 32'h0000_0002, "R12 summary1 upper");
        hart_halted = '0;

        // R5 command launch
        apb_wr(8'h04, 32'h0000_0011);
        apb_wr(8'h17, 32'h0023_1005);
        check("R5 start pulse", {31'b0, cmd_start}, 32'h1);
        check("R5 cmd_word", cmd_word, 32'h0023_1005);
        check("R5 cmd_arg", cmd_arg, 32'h0000_0011);
        @(negedge clk); #0.5;
        check("R5 start one cycle", {31'b0, cmd_start}, 32'h0);
        apb_rd(8'h16, 32'h0100_1001, "R5 busy");

        // R6 command while busy
        apb_wr(8'h17, 32'h0000_0999);
        apb_rd(8'h16, 32'h0100_1101, "R6 busy error");
        hart_finish(1'b0, 32'hDEAD_BEEF);
        check("R6 command kept", cmd_word, 32'h0023_1005);
        apb_rd(8'h04, 32'h0000_0011, "R9 write-type no result copy");

        // R7 command with error pending
        apb_wr(8'h17, 32'h0022_0300);
        check("R7 no start", {31'b0, cmd_start}, 32'h0);
        apb_rd(8'h16, 32'h0100_0101, "R7 error unchanged");

        // R10 clear
        apb_wr(8'h16, 32'h0000_0700);
        apb_rd(8'h16, 32'h0100_0001, "R10 cleared");

        // R9 result copy
        apb_wr(8'h17, 32'h0022_0300);
        check("R9 start", {31'b0, cmd_start}, 32'h1);
        hart_finish(1'b0, 32'h0000_CAFE);
        apb_rd(8'h04, 32'h0000_CAFE, "R9 result in data");
        apb_rd(8'h16, 32'h0100_0001, "R9 idle");

        // R8 progbuf write while busy
        apb_wr(8'h20, 32'h0000_0013);
        apb_wr(8'h17, 32'h0023_0300);
        apb_wr(8'h20, 32'h0000_1234);
        hart_finish(1'b0, 32'h0);
        apb_rd(8'h20, 32'h0000_0013, "R8 progbuf unchanged");
        apb_rd(8'h16, 32'h0100_0101, "R8 error set");
        apb_wr(8'h16, 32'h0000_0100);

        // R8 data read while busy
        apb_wr(8'h17, 32'h0023_0300);
        apb_rd(8'h04, 32'h0000_CAFE, "R8 data read busy");
        hart_finish(1'b0, 32'h0);
        apb_rd(8'h16, 32'h0100_0101, "R8 read sets error");
        apb_wr(8'h16, 32'h0000_0100);

        // R9 exception
        apb_wr(8'h17, 32'h0022_0300);
        hart_finish(1'b1, 32'h5555_5555);
        apb_rd(8'h16, 32'h0100_0301, "R9 exception error");
        apb_rd(8'h04, 32'h0000_CAFE, "R9 no copy on exception");
        apb_wr(8'h16, 32'h0000_0300);

        // R11 auto-execution
        apb_wr(8'h18, 32'h0001_0001);
        apb_rd(8'h18, 32'h0001_0001, "R11 auto readback");
        hart_finish(1'b0, 32'h0000_0abc);
        apb_wr(8'h04, 32'h0000_0077);
        check("R11 data start", {31'b0, cmd_start}, 32'h1);
        check("R11 data arg", cmd_arg, 32'h0000_0077);
        check("R11 last command", cmd_word, 32'h0022_0300);
        hart_finish(1'b0, 32'h0000_0088);
        apb_wr(8'h20, 32'h0000_0ABC);
        check("R11 progbuf start", {31'b0, cmd_start}, 32'h1);
        check("R11 progbuf instr", cmd_instr, 32'h0000_0ABC);
        hart_finish(1'b0, 32'h0);
        apb_wr(8'h18, 32'h0);
        apb_wr(8'h04, 32'h0000_0001);
        check("R11 disabled no start", {31'b0, cmd_start}, 32'h0);
        apb_rd(8'h16, 32'h0100_0001, "R11 idle");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule